// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold and Trailing Interrupts

This block sits between a processor-side register port and a serial bus engine. It holds one byte queue for each direction. Software writes bytes into the transmit queue, and the engine drains them with a pop strobe. The engine fills the receive queue with a push strobe, and software drains it by reading a data register.

Each queue has its own enable bit and its own programmable threshold. A status word reports the fill level and the empty and full flags of both queues. A seven-bit interrupt status register latches these events: threshold crossings, overruns, underruns and a trailing-data timeout. The timeout fires when received bytes sit in the queue below the threshold and nothing more arrives. Status bits are cleared by writing one to them. A per-bit enable mask selects which of them drive the single interrupt line.

Register word addresses on `reg_addr` are: 0 control, 1 trailing length, 2 interrupt enable, 3 interrupt status, 4 FIFO status, 5 transmit data (write), 6 receive data (read). Reads are combinational from `reg_addr` and take effect in the same cycle.

Top module: `dual_fifo_irq`

## Requirements
- R1: Control bit 0 enables the receive queue and bit 1 enables the transmit queue. While its bit is clear, a queue reads as empty with level zero. Pushes and pops to it are ignored, and it raises no overrun or underrun.
- R2: The FIFO status word holds the transmit level in [6:0], transmit full at bit 7 and transmit empty at bit 8. It holds the receive level in [22:16], receive full at bit 23 and receive empty at bit 24.
- R3: Each queue returns bytes in arrival order. Transmit bytes appear on `eng_tx_data` while `eng_tx_pop` is high. Receive bytes appear on `reg_rdata[7:0]` during a read of address 6.
- R4: The receive threshold is control field [10:4] and the transmit threshold is field [22:16]. Status bit 1 (receive almost-full) sets while the receive queue is enabled and its level is at or above its threshold. Status bit 0 (transmit almost-empty) sets while the transmit queue is enabled and its level is at or below its threshold.
- R5: A push into a full queue is dropped. It sets status bit 3 for the transmit side or bit 5 for the receive side.
- R6: A pop from an empty queue returns zero. It sets status bit 2 for the transmit side or bit 4 for the receive side.
- R7: Status bit 6 (trailing) sets T+1 cycles after the clock edge that accepted the last receive push, while the receive queue stays non-empty. T is register 1 field [3:0].
- R8: Writing ones to address 3 clears those status bits, except where the same bit's condition sets it in that cycle. `irq` is high exactly when some status bit and its enable bit in address 2 [6:0] are both set.
- R9: After reset the control and enable registers are zero, the trailing length is 0xF, the status is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive queue at address 6 |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | DATA_W | Transmit head byte, zero when empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | DATA_W | Received byte |
| irq | output | 1 | Masked interrupt output |

## Verification
Queue levels, flags and head data change at the edge that samples a strobe. They are read back in the following cycle. Threshold and trailing status bits are one register further on, because a status bit latches its condition one edge after the condition holds. The bench therefore waits at least one idle edge before it reads status after a level change. The trailing bit is sampled exactly after T and after T+1 edges from the last push, and must be low and then high. Inputs are driven at the falling edge, and all sampling happens shortly after it, so each read sees the values left by the previous rising edge.

// File: rtl/dual_fifo_pkg.sv
package dual_fifo_pkg;
   localparam int REG_AW    = 3;
   localparam int REG_DW    = 32;
   localparam int LVL_FW    = 7;
   localparam int NUM_EVT   = 7;

   localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] RA_TRAIL  = 3'd1;
   localparam logic [REG_AW-1:0] RA_IEN    = 3'd2;
   localparam logic [REG_AW-1:0] RA_ISTAT  = 3'd3;
   localparam logic [REG_AW-1:0] RA_FSTAT  = 3'd4;
   localparam logic [REG_AW-1:0] RA_TXDATA = 3'd5;
   localparam logic [REG_AW-1:0] RA_RXDATA = 3'd6;

   localparam int CB_RX_EN   = 0;
   localparam int CB_TX_EN   = 1;
   localparam int CB_RX_TRIG = 4;
   localparam int CB_TX_TRIG = 16;

   localparam int SB_TX_LVL   = 0;
   localparam int SB_TX_FULL  = 7;
   localparam int SB_TX_EMPTY = 8;
   localparam int SB_RX_LVL   = 16;
   localparam int SB_RX_FULL  = 23;
   localparam int SB_RX_EMPTY = 24;

   localparam int EV_TX_AE  = 0;
   localparam int EV_RX_AF  = 1;
   localparam int EV_TX_UDF = 2;
   localparam int EV_TX_OVF = 3;
   localparam int EV_RX_UDF = 4;
   localparam int EV_RX_OVF = 5;
   localparam int EV_TRAIL  = 6;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [LW-1:0]     level,
   output logic              full,
   output logic              empty,
   output logic              ovf,
   output logic              udf
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic              do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~flush & ~full;
   assign do_pop  = pop & ~flush & ~empty;
   assign ovf     = push & ~flush & full;
   assign udf     = pop & ~flush & empty;
   assign head    = empty ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end
endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             arrive,
   input  logic [CNT_W-1:0] limit,
   output logic             fire
);
   logic [CNT_W-1:0] idle_cnt;

   assign fire = active & ~arrive & (idle_cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !active || arrive) idle_cnt <= '0;
      else if (idle_cnt != limit)      idle_cnt <= idle_cnt + 1'b1;
   end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] ien,
   output logic [N-1:0] stat,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= set[i] | (stat[i] & ~clr[i]);
      end
   end

   assign irq = |(stat & ien);
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
   import dual_fifo_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 8,
   parameter int TRAIL_W = 4,
   parameter logic [TRAIL_W-1:0] TRAIL_RST = '1,
   localparam int LW     = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   output logic              irq
);
   if (!(DEPTH == 16 || DEPTH == 64)) begin : g_bad_depth
      $error("DEPTH must be 16 or 64");
   end
   if (DATA_W < 1 || DATA_W > 8) begin : g_bad_dw
      $error("DATA_W must be 1..8");
   end
   if (TRAIL_W < 1 || TRAIL_W > 4) begin : g_bad_tw
      $error("TRAIL_W must be 1..4");
   end

   logic                 rx_en, tx_en;
   logic [LVL_FW-1:0]    rx_trig, tx_trig;
   logic [TRAIL_W-1:0]   trail_len;
   logic [NUM_EVT-1:0]   ien, istat, ev_set, ev_clr;
   logic [LW-1:0]        tx_lvl, rx_lvl;
   logic [LVL_FW-1:0]    tx_lvl7, rx_lvl7;
   logic                 tx_full, tx_empty, rx_full, rx_empty;
   logic                 tx_ovf, tx_udf, rx_ovf, rx_udf;
   logic [DATA_W-1:0]    rx_head;
   logic                 tx_wr, rx_pop, trail_fire;
   logic                 unused_wbits;

   assign tx_wr  = reg_wr && (reg_addr == RA_TXDATA);
   assign rx_pop = reg_rd && (reg_addr == RA_RXDATA);
   assign unused_wbits = ^{reg_wdata[31:23], reg_wdata[15:11]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
         rx_trig   <= '0;
         tx_trig   <= '0;
         trail_len <= TRAIL_RST;
         ien       <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_CTRL: begin
               rx_en   <= reg_wdata[CB_RX_EN];
               tx_en   <= reg_wdata[CB_TX_EN];
               rx_trig <= reg_wdata[CB_RX_TRIG +: LVL_FW];
               tx_trig <= reg_wdata[CB_TX_TRIG +: LVL_FW];
            end
            RA_TRAIL: trail_len <= reg_wdata[TRAIL_W-1:0];
            RA_IEN:   ien       <= reg_wdata[NUM_EVT-1:0];
            default: ;
         endcase
      end
   end

   byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(~tx_en),
      .push(tx_wr), .wdata(reg_wdata[DATA_W-1:0]),
      .pop(eng_tx_pop), .head(eng_tx_data),
      .level(tx_lvl), .full(tx_full), .empty(tx_empty),
      .ovf(tx_ovf), .udf(tx_udf)
   );

   byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(~rx_en),
      .push(eng_rx_push), .wdata(eng_rx_data),
      .pop(rx_pop), .head(rx_head),
      .level(rx_lvl), .full(rx_full), .empty(rx_empty),
      .ovf(rx_ovf), .udf(rx_udf)
   );

   trail_timer #(.CNT_W(TRAIL_W)) u_trail (
      .clk(clk), .rst_n(rst_n),
      .active(rx_en & ~rx_empty),
      .arrive(eng_rx_push & rx_en),
      .limit(trail_len),
      .fire(trail_fire)
   );

   assign tx_lvl7 = LVL_FW'(tx_lvl);
   assign rx_lvl7 = LVL_FW'(rx_lvl);

   always_comb begin
      ev_set            = '0;
      ev_set[EV_TX_AE]  = tx_en & (tx_lvl7 <= tx_trig);
      ev_set[EV_RX_AF]  = rx_en & (rx_lvl7 >= rx_trig);
      ev_set[EV_TX_UDF] = tx_udf;
      ev_set[EV_TX_OVF] = tx_ovf;
      ev_set[EV_RX_UDF] = rx_udf;
      ev_set[EV_RX_OVF] = rx_ovf;
      ev_set[EV_TRAIL]  = trail_fire;
   end

   assign ev_clr = (reg_wr && reg_addr == RA_ISTAT) ? reg_wdata[NUM_EVT-1:0] : '0;

   irq_status #(.N(NUM_EVT)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .set(ev_set), .clr(ev_clr), .ien(ien),
      .stat(istat), .irq(irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CB_RX_EN]               = rx_en;
            reg_rdata[CB_TX_EN]               = tx_en;
            reg_rdata[CB_RX_TRIG +: LVL_FW]   = rx_trig;
            reg_rdata[CB_TX_TRIG +: LVL_FW]   = tx_trig;
         end
         RA_TRAIL: reg_rdata[TRAIL_W-1:0] = trail_len;
         RA_IEN:   reg_rdata[NUM_EVT-1:0] = ien;
         RA_ISTAT: reg_rdata[NUM_EVT-1:0] = istat;
         RA_FSTAT: begin
            reg_rdata[SB_TX_LVL +: LVL_FW] = tx_lvl7;
            reg_rdata[SB_TX_FULL]          = tx_full;
            reg_rdata[SB_TX_EMPTY]         = tx_empty;
            reg_rdata[SB_RX_LVL +: LVL_FW] = rx_lvl7;
            reg_rdata[SB_RX_FULL]          = rx_full;
            reg_rdata[SB_RX_EMPTY]         = rx_empty;
         end
         RA_RXDATA: reg_rdata[DATA_W-1:0] = rx_head;
         default: ;
      endcase
   end
endmodule

// File: rtl/dual_fifo_irq_chk.sv
module dual_fifo_irq_chk #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int LW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LW-1:0]     tx_lvl,
   input logic [LW-1:0]     rx_lvl,
   input logic              tx_full,
   input logic              tx_empty,
   input logic              rx_full,
   input logic              rx_empty,
   input logic              rx_en,
   input logic              rx_pop,
   input logic              eng_rx_push,
   input logic              eng_tx_pop,
   input logic [DATA_W-1:0] eng_tx_data,
   input logic              irq,
   input logic [6:0]        ien,
   input logic              trail_bit
);
   assert_lvl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

   assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full && tx_empty) && !(rx_full && rx_empty));

   assert_drop_on_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_full && !rx_pop) |=> rx_full);

   assert_underrun_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_pop && tx_empty) |-> (eng_tx_data == '0));

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien != '0));

   assert_disabled_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (rx_lvl == '0));

   assert_trail_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trail_bit) |-> !$past(rx_empty));
endmodule

bind dual_fifo_irq dual_fifo_irq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
   .tx_full(tx_full), .tx_empty(tx_empty),
   .rx_full(rx_full), .rx_empty(rx_empty),
   .rx_en(rx_en), .rx_pop(rx_pop),
   .eng_rx_push(eng_rx_push), .eng_tx_pop(eng_tx_pop),
   .eng_tx_data(eng_tx_data), .irq(irq), .ien(ien),
   .trail_bit(istat[6])
);

// File: tb/dual_fifo_irq_tb.sv
`timescale 1ns/1ps
module dual_fifo_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [7:0]  eng_tx_data;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = '0;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   logic mon_on = 1'b1;
   logic [31:0] v;

   always #4 clk = ~clk;

   dual_fifo_irq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares data leaving each queue against the scoreboard
   always begin
      @(negedge clk);
      #2;
      if (mon_on && eng_tx_pop) begin
         if (txq.size() == 0) chk("R3 tx extra pop", 32'(eng_tx_data), 32'hDEAD);
         else chk("R3 tx order", 32'(eng_tx_data), 32'(txq.pop_front()));
      end
      if (mon_on && reg_rd && reg_addr == 3'd6) begin
         if (rxq.size() == 0) chk("R3 rx extra read", reg_rdata, 32'hDEAD);
         else chk("R3 rx order", reg_rdata, 32'(rxq.pop_front()));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1 reg_rd = 1'b0;
   endtask

   task automatic tx_put(input logic [7:0] b, input bit expect_keep);
      if (expect_keep) txq.push_back(b);
      wr(3'd5, 32'(b));
   endtask

   task automatic eng_push(input logic [7:0] b, input bit expect_keep);
      if (expect_keep) rxq.push_back(b);
      @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
      @(posedge clk); #1 eng_rx_push = 1'b0;
   endtask

   task automatic eng_pop();
      @(negedge clk); eng_tx_pop = 1'b1;
      @(posedge clk); #1 eng_tx_pop = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 reset state
      @(negedge clk); #1 chk("R9 irq", 32'(irq), 0);
      rd(3'd0, v); chk("R9 ctrl", v, 0);
      rd(3'd1, v); chk("R9 trail", v, 32'hF);
      rd(3'd2, v); chk("R9 ien", v, 0);
      rd(3'd3, v); chk("R9 istat", v, 0);
      rd(3'd4, v); chk("R2 R9 fstat empty", v, 32'h0100_0100);

      // R1 disabled queues ignore traffic
      mon_on = 1'b0;
      eng_push(8'h55, 0);
      wr(3'd5, 32'h66);
      eng_pop();
      rd(3'd6, v); chk("R1 rx read while off", v, 0);
      idle(2);
      rd(3'd4, v); chk("R1 fstat off", v, 32'h0100_0100);
      rd(3'd3, v); chk("R1 no events off", v, 0);
      mon_on = 1'b1;

      // enable: rx trig 4, tx trig 2
      wr(3'd0, 32'h0002_0043);
      rd(3'd0, v); chk("R4 ctrl readback", v, 32'h0002_0043);
      rd(3'd3, v); chk("R4 tx almost-empty at 0", v, 32'h1);

      for (int i = 0; i < 5; i++) tx_put(8'hA1 + 8'(i), 1);
      rd(3'd4, v); chk("R2 tx level 5", v, 32'h0100_0005);
      wr(3'd3, 32'h7F);
      rd(3'd3, v); chk("R8 w1c clears", v, 0);

      for (int i = 0; i < 3; i++) eng_pop();
      idle(1);
      rd(3'd3, v); chk("R4 tx almost-empty at trig", v & 32'h1, 32'h1);

      wr(3'd2, 32'h1);
      @(negedge clk); #1 chk("R8 irq enabled", 32'(irq), 1);
      wr(3'd2, 32'h0);
      @(negedge clk); #1 chk("R8 irq masked", 32'(irq), 0);

      eng_pop(); eng_pop();
      mon_on = 1'b0;
      @(negedge clk); eng_tx_pop = 1'b1;
      #1 chk("R6 tx empty pop data", 32'(eng_tx_data), 0);
      @(posedge clk); #1 eng_tx_pop = 1'b0;
      mon_on = 1'b1;
      idle(1);
      rd(3'd3, v); chk("R6 tx underrun bit", v & 32'h0C, 32'h04);

      // R5 tx overrun
      wr(3'd3, 32'h7F);
      for (int i = 0; i < 16; i++) tx_put(8'h10 + 8'(i), 1);
      tx_put(8'hEE, 0);
      idle(1);
      rd(3'd4, v); chk("R2 R5 tx full", v & 32'h1FF, 32'h090);
      rd(3'd3, v); chk("R5 tx overrun bit", v & 32'h0C, 32'h08);
      for (int i = 0; i < 16; i++) eng_pop();
      chk("R3 R5 tx drained", 32'(txq.size()), 0);

      // R7 trailing timeout with T=3
      wr(3'd1, 32'h3);
      rd(3'd1, v); chk("R7 trail reg", v, 32'h3);
      wr(3'd3, 32'h7F);
      eng_push(8'hC0, 1); eng_push(8'hC1, 1); eng_push(8'hC2, 1);
      repeat (3) @(posedge clk);
      rd(3'd3, v); chk("R7 trail not yet", v & 32'h42, 32'h00);
      rd(3'd3, v); chk("R7 trail fires", v & 32'h42, 32'h40);
      for (int i = 0; i < 3; i++) rd(3'd6, v);
      mon_on = 1'b0;
      rd(3'd6, v); chk("R6 rx empty read data", v, 0);
      mon_on = 1'b1;
      idle(1);
      rd(3'd3, v); chk("R6 rx underrun bit", v & 32'h10, 32'h10);

      // R4 almost-full, R5 rx overrun
      wr(3'd3, 32'h7F);
      for (int i = 0; i < 4; i++) eng_push(8'h30 + 8'(i), 1);
      idle(1);
      rd(3'd3, v); chk("R4 rx almost-full", v & 32'h22, 32'h02);
      for (int i = 4; i < 16; i++) eng_push(8'h30 + 8'(i), 1);
      eng_push(8'hFF, 0);
      idle(1);
      rd(3'd4, v); chk("R2 R5 rx full", (v >> 16) & 32'h1FF, 32'h090);
      rd(3'd3, v); chk("R5 rx overrun bit", v & 32'h20, 32'h20);
      for (int i = 0; i < 16; i++) rd(3'd6, v);
      chk("R3 R5 rx drained", 32'(rxq.size()), 0);

      // R8 set wins over clear (tx empty, trigger 2)
      wr(3'd3, 32'h01);
      rd(3'd3, v); chk("R8 set beats clear", v & 32'h1, 32'h1);

      // R1 disabling flushes and ignores pushes
      mon_on = 1'b0;
      eng_push(8'h01, 0); eng_push(8'h02, 0);
      wr(3'd0, 32'h0002_0042);
      wr(3'd3, 32'h7F);
      eng_push(8'h03, 0);
      idle(1);
      rd(3'd4, v); chk("R1 rx flushed", (v >> 16) & 32'h1FF, 32'h100);
      rd(3'd3, v); chk("R1 no rx events", v & 32'h72, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule